// File: doc/BRIEF.md
# Amplifier protection fault manager

This block sits between the analog threshold comparators of a multi-channel class-D power stage and its output drivers. It takes a digitized junction temperature, two charge-pump hold-voltage crossing flags, a supply undervoltage flag and a supply overvoltage flag. From these it produces the amplifier-wide protective commands: a thermal warning, a global channel disable, an all-outputs three-state command, a half-supply regulation command, a latched standby bit and the enable of an active-low open-drain fault pin. It also provides a status image that a register file can read.

Every comparator input first passes through a two-flop synchronizer. The protection state is then decided one register later. The thermal warning limit is picked by a 2-bit code. The warning only reports; it never acts on the outputs. Thermal shutdown and charge-pump undervoltage each have hysteresis. An overvoltage event forces standby, and standby stays set until software clears it after the overvoltage has gone. No fault resets or alters anything outside this block, so register contents and the bus interface stay intact.

Top module: `amp_fault_mgr`

## Requirements
- R1: The thermal warning limit is 110 + 10 × `warn_sel` degrees. `therm_warn` is 1 exactly when the synchronized temperature code is strictly greater than the limit, and it clears by itself when the code is at or below the limit.
- R2: The thermal warning takes no protective action. With only the warning active, `chan_disable`, `out_tristate`, `out_halfsup` and `fault_od_en` all stay 0.
- R3: Thermal shutdown (`chan_disable`) sets when the temperature code is above 150. It clears only when the code is below 140. For codes from 140 to 150 inclusive it holds its previous value.
- R4: The charge-pump undervoltage state sets while the low-crossing flag is 1 and clears only when the high-crossing flag is 1 and the low flag is 0. With both flags at 0 it holds. Its reset value is 1. While it is set, `out_tristate` is 1 (unless R6 applies).
- R5: During supply undervoltage, `out_tristate` is 1, status bit 3 (supply-ok) is 0 and `fault_od_en` is 1.
- R6: During supply overvoltage, status bit 4 (overvoltage-ok) is 0, `fault_od_en` is 1, `standby` is forced to 1, `out_halfsup` is 1 and `out_tristate` is 0. `out_tristate` and `out_halfsup` are never 1 together.
- R7: A software write (`stby_wr` with `stby_wdata`) sets `standby` to the written value on the next clock edge. A write is ignored while the synchronized overvoltage flag is 1, which includes a write in the same cycle as an overvoltage. `standby` stays 1 after the overvoltage leaves until software writes 0.
- R8: `fault_od_en` is 1 exactly when supply undervoltage, supply overvoltage or thermal shutdown is active.
- R9: Status image layout: bit 0 warning, bit 1 thermal shutdown, bit 2 charge-pump undervoltage (1 = under), bit 3 supply-ok (0 = undervoltage), bit 4 overvoltage-ok (0 = overvoltage), bit 5 standby.
- R10: A change on a comparator input or on the temperature code shows at the outputs on the third rising clock edge after it is applied, and not before.
- R11: After reset, warning and shutdown are 0, charge-pump undervoltage is 1, standby is 1, and the status image reads 0x3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| temp_code | input | 8 | Junction temperature in degrees, unsigned |
| warn_sel | input | 2 | Warning limit select, 110 to 140 degrees in 10-degree steps |
| cp_below_lo | input | 1 | Charge-pump hold voltage below the lower crossing |
| cp_above_hi | input | 1 | Charge-pump hold voltage above the upper crossing |
| supply_uv | input | 1 | Supply undervoltage comparator |
| supply_ov | input | 1 | Supply overvoltage comparator |
| stby_wr | input | 1 | Software write strobe for the standby bit |
| stby_wdata | input | 1 | Value written to the standby bit |
| therm_warn | output | 1 | Thermal warning, report only |
| chan_disable | output | 1 | Thermal shutdown: disable all channels |
| out_tristate | output | 1 | Three-state all outputs |
| out_halfsup | output | 1 | Regulate all outputs to half supply |
| standby | output | 1 | Latched standby bit |
| fault_od_en | output | 1 | Pull-down enable of the active-low open-drain fault pin |
| status | output | 6 | Status image, layout per R9 |

## Verification
Two functions can decide the same cycle. The first pair is an overvoltage forcing standby and a software write clearing it. The second pair is undervoltage and overvoltage together, where the three-state command and the half-supply command compete. The supply sweep runs all sixteen combinations of the four supply flags in forward order and then in reverse order. Right after each settle it issues a standby write while the new overvoltage level is already synchronized. An arithmetic bench model expects the overvoltage set to win and the half-supply command to suppress three-state. The temperature sweeps rise and then fall across every code for each limit setting, which tests the shutdown hysteresis band from both sides.

// File: rtl/fm_pkg.sv
package fm_pkg;

  localparam int TEMP_W     = 8;
  localparam int SEL_W      = 2;
  localparam int STATUS_W   = 6;
  localparam int FLAG_W     = 4;

  // index of each comparator flag inside the synchronized flag vector
  localparam int FLG_CP_LO  = 0;
  localparam int FLG_CP_HI  = 1;
  localparam int FLG_UV     = 2;
  localparam int FLG_OV     = 3;

  // status image, bit 0 is the last member
  typedef struct packed {
    logic stby;
    logic ov_ok;
    logic uv_ok;
    logic cpuv;
    logic tsd;
    logic warn;
  } fm_status_t;

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fm_rst_sync.sv
module fm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] rel_q;
  logic [STAGES-1:0] rel_d;

  generate
    if (STAGES == 1) begin : g_single
      assign rel_d = 1'b1;
    end else begin : g_chain
      assign rel_d = {rel_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rel_q <= '0;
    else         rel_q <= rel_d;
  end

  assign rst_n_o = rel_q[STAGES-1];

endmodule

// File: rtl/fm_thermal.sv
module fm_thermal
  import fm_pkg::*;
#(
  parameter int WARN_BASE = 110,
  parameter int WARN_STEP = 10,
  parameter int TSD_SET   = 150,
  parameter int TSD_CLR   = 140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_s,
  input  logic [SEL_W-1:0]  warn_sel,
  output logic              warn_o,
  output logic              tsd_o
);

  localparam logic [TEMP_W-1:0] BASE_C = TEMP_W'(WARN_BASE);
  localparam logic [TEMP_W-1:0] STEP_C = TEMP_W'(WARN_STEP);
  localparam logic [TEMP_W-1:0] SET_C  = TEMP_W'(TSD_SET);
  localparam logic [TEMP_W-1:0] CLR_C  = TEMP_W'(TSD_CLR);

  logic [TEMP_W-1:0] limit;
  logic              warn_d, warn_q;
  logic              tsd_d, tsd_q, tsd_en;

  // next state
  always_comb begin
    limit  = BASE_C + STEP_C * TEMP_W'(warn_sel);
    warn_d = (temp_s > limit);
    tsd_en = (temp_s > SET_C) || (temp_s < CLR_C);
    tsd_d  = (temp_s > SET_C);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      tsd_q  <= 1'b0;
    end else begin
      warn_q <= warn_d;
      if (tsd_en) tsd_q <= tsd_d;
    end
  end

  assign warn_o = warn_q;
  assign tsd_o  = tsd_q;

  assert_warn_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_q) |-> ($past(temp_s) > $past(limit)));

  assert_tsd_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsd_q) |-> ($past(temp_s) > SET_C));

  assert_tsd_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tsd_q) |-> ($past(temp_s) < CLR_C));

  assert_tsd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_q && temp_s >= CLR_C) |=> tsd_q);

endmodule

// File: rtl/fm_supply.sv
module fm_supply (
  input  logic clk,
  input  logic rst_n,
  input  logic cp_lo_s,
  input  logic cp_hi_s,
  input  logic uv_s,
  input  logic ov_s,
  input  logic stby_wr,
  input  logic stby_wdata,
  output logic cpuv_o,
  output logic uv_o,
  output logic ov_o,
  output logic stby_o
);

  logic cpuv_d, cpuv_q, cpuv_en;
  logic stby_d, stby_q, stby_en;
  logic uv_q, ov_q;

  // next state
  always_comb begin
    cpuv_en = cp_lo_s || cp_hi_s;
    cpuv_d  = cp_lo_s;
    stby_en = ov_s || stby_wr;
    stby_d  = ov_s || stby_wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpuv_q <= 1'b1;
      stby_q <= 1'b1;
      uv_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      uv_q <= uv_s;
      ov_q <= ov_s;
      if (cpuv_en) cpuv_q <= cpuv_d;
      if (stby_en) stby_q <= stby_d;
    end
  end

  assign cpuv_o = cpuv_q;
  assign uv_o   = uv_q;
  assign ov_o   = ov_q;
  assign stby_o = stby_q;

  assert_cpuv_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpuv_q) |-> ($past(cp_hi_s) && !$past(cp_lo_s)));

  assert_cpuv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp_lo_s && !cp_hi_s) |=> $stable(cpuv_q));

  assert_ov_forces_stby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_s |=> stby_q);

  assert_stby_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby_q) |-> ($past(stby_wr) && !$past(ov_s)));

endmodule

// File: rtl/amp_fault_mgr.sv
module amp_fault_mgr
  import fm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WARN_BASE   = 110,
  parameter int WARN_STEP   = 10,
  parameter int TSD_SET     = 150,
  parameter int TSD_CLR     = 140
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TEMP_W-1:0]   temp_code,
  input  logic [SEL_W-1:0]    warn_sel,
  input  logic                cp_below_lo,
  input  logic                cp_above_hi,
  input  logic                supply_uv,
  input  logic                supply_ov,
  input  logic                stby_wr,
  input  logic                stby_wdata,
  output logic                therm_warn,
  output logic                chan_disable,
  output logic                out_tristate,
  output logic                out_halfsup,
  output logic                standby,
  output logic                fault_od_en,
  output logic [STATUS_W-1:0] status
);

  logic              rst_n_s;
  logic [FLAG_W-1:0] flags_raw, flags_s;
  logic [TEMP_W-1:0] temp_s;
  logic              warn, tsd, cpuv, uv, ov, stby;
  fm_status_t        stat;

  fm_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  always_comb begin
    flags_raw            = '0;
    flags_raw[FLG_CP_LO] = cp_below_lo;
    flags_raw[FLG_CP_HI] = cp_above_hi;
    flags_raw[FLG_UV]    = supply_uv;
    flags_raw[FLG_OV]    = supply_ov;
  end

  fm_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) i_flag_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (flags_raw),
    .q     (flags_s)
  );

  // the converter holds each code for many cycles, so a plain chain suffices
  fm_sync #(.WIDTH(TEMP_W), .STAGES(SYNC_STAGES)) i_temp_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (temp_code),
    .q     (temp_s)
  );

  fm_thermal #(
    .WARN_BASE (WARN_BASE),
    .WARN_STEP (WARN_STEP),
    .TSD_SET   (TSD_SET),
    .TSD_CLR   (TSD_CLR)
  ) i_thermal (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .temp_s   (temp_s),
    .warn_sel (warn_sel),
    .warn_o   (warn),
    .tsd_o    (tsd)
  );

  fm_supply i_supply (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cp_lo_s    (flags_s[FLG_CP_LO]),
    .cp_hi_s    (flags_s[FLG_CP_HI]),
    .uv_s       (flags_s[FLG_UV]),
    .ov_s       (flags_s[FLG_OV]),
    .stby_wr    (stby_wr),
    .stby_wdata (stby_wdata),
    .cpuv_o     (cpuv),
    .uv_o       (uv),
    .ov_o       (ov),
    .stby_o     (stby)
  );

  always_comb begin
    stat.warn  = warn;
    stat.tsd   = tsd;
    stat.cpuv  = cpuv;
    stat.uv_ok = ~uv;
    stat.ov_ok = ~ov;
    stat.stby  = stby;
  end

  assign therm_warn   = warn;
  assign chan_disable = tsd;
  assign out_halfsup  = ov;
  assign out_tristate = (cpuv | uv) & ~ov;
  assign standby      = stby;
  assign fault_od_en  = uv | ov | tsd;
  assign status       = stat;

  assert_drive_excl_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(out_tristate && out_halfsup));

  assert_ov_standby_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_halfsup |-> standby);

  assert_warn_passive_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (therm_warn && !chan_disable && !status[3] == 1'b0 && status[4]) |-> !fault_od_en);

  assert_fault_pin_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (chan_disable || !status[3] || !status[4]) |-> fault_od_en);

endmodule

// File: tb/test_amp_fault_mgr.sv
module test_amp_fault_mgr;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] temp_code;
  logic [1:0] warn_sel;
  logic       cp_below_lo, cp_above_hi, supply_uv, supply_ov;
  logic       stby_wr, stby_wdata;
  logic       therm_warn, chan_disable, out_tristate, out_halfsup;
  logic       standby, fault_od_en;
  logic [5:0] status;

  int vectors     = 0;
  int miscompares = 0;
  bit finished    = 1'b0;

  // bench model state
  bit m_tsd, m_cpuv, m_stby;

  always #5 clk = ~clk;

  amp_fault_mgr i_amp_fault_mgr (
    .clk          (clk),
    .rst_n        (rst_n),
    .temp_code    (temp_code),
    .warn_sel     (warn_sel),
    .cp_below_lo  (cp_below_lo),
    .cp_above_hi  (cp_above_hi),
    .supply_uv    (supply_uv),
    .supply_ov    (supply_ov),
    .stby_wr      (stby_wr),
    .stby_wdata   (stby_wdata),
    .therm_warn   (therm_warn),
    .chan_disable (chan_disable),
    .out_tristate (out_tristate),
    .out_halfsup  (out_halfsup),
    .standby      (standby),
    .fault_od_en  (fault_od_en),
    .status       (status)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_write(input bit v);
    stby_wr    = 1'b1;
    stby_wdata = v;
    @(negedge clk);
    stby_wr    = 1'b0;
    stby_wdata = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    temp_code = 8'd25; warn_sel = 2'd0;
    cp_below_lo = 1'b0; cp_above_hi = 1'b0; supply_uv = 1'b0; supply_ov = 1'b0;
    stby_wr = 1'b0; stby_wdata = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R11 reset state
    chk("R11", "status after reset", status, 6'h3C);
    chk("R11", "standby after reset", standby, 1'b1);
    chk("R11", "warn/tsd after reset", {therm_warn, chan_disable}, 2'b00);
    chk("R4", "cpuv reset forces tristate", out_tristate, 1'b1);
    m_tsd = 0; m_cpuv = 1; m_stby = 1;

    // clear charge-pump undervoltage, then release the upper flag (hold)
    cp_above_hi = 1'b1; settle();
    cp_above_hi = 1'b0; settle();
    m_cpuv = 0;
    chk("R4", "cpuv cleared by upper crossing", {status[2], out_tristate}, 2'b00);

    // thermal sweep: every code, rising then falling, each limit setting
    for (int sel = 0; sel < 4; sel++) begin
      warn_sel = 2'(sel);
      for (int dir = 0; dir < 2; dir++) begin
        for (int k = 0; k <= 200; k++) begin
          int t;
          bit e_warn;
          t = (dir == 0) ? k : 200 - k;
          temp_code = 8'(t);
          settle();
          e_warn = (t > 110 + 10 * sel);
          if (t > 150) m_tsd = 1;
          else if (t < 140) m_tsd = 0;
          chk("R1", "warning", therm_warn, e_warn);
          chk("R3", "shutdown", chan_disable, m_tsd);
          chk("R8", "fault pin thermal", fault_od_en, m_tsd);
          chk("R9", "status thermal", status,
              {1'b1, 1'b1, 1'b1, 1'b0, m_tsd, e_warn});
          if (e_warn && !m_tsd)
            chk("R2", "warning is passive",
                {chan_disable, out_tristate, out_halfsup, fault_od_en}, 4'b0000);
        end
      end
    end

    // supply sweep: all flag combinations forward then reverse
    temp_code = 8'd25; settle(); m_tsd = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 16; k++) begin
        int c;
        bit lo, hi, uv, ov;
        c  = (pass == 0) ? k : 15 - k;
        lo = c[0]; hi = c[1]; uv = c[2]; ov = c[3];
        cp_below_lo = lo; cp_above_hi = hi; supply_uv = uv; supply_ov = ov;
        settle();
        if (lo) m_cpuv = 1; else if (hi) m_cpuv = 0;
        if (ov) m_stby = 1;
        chk("R4", "cpuv state", status[2], m_cpuv);
        chk("R5", "tristate", out_tristate, (m_cpuv | uv) & ~ov);
        chk("R6", "halfsupply", out_halfsup, ov);
        chk("R8", "fault pin supply", fault_od_en, uv | ov);
        chk("R9", "status supply", status,
            {m_stby, ~ov, ~uv, m_cpuv, 1'b0, 1'b0});
        // write in the cycle the synchronized overvoltage is already present
        sw_write(c % 3 == 0);
        if (!ov) m_stby = (c % 3 == 0);
        chk("R7", "standby after write", standby, m_stby);
      end
    end

    // leave overvoltage: standby stays until software clears it
    cp_below_lo = 0; cp_above_hi = 1; supply_uv = 0; supply_ov = 1; settle();
    supply_ov = 0; settle();
    chk("R7", "standby kept after ov left", standby, 1'b1);
    sw_write(1'b0);
    chk("R7", "standby cleared by software", standby, 1'b0);
    chk("R6", "ov gone no halfsupply", {out_halfsup, status[4]}, 2'b01);

    // R10 latency: visible on the third edge, not the second
    supply_uv = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10", "uv not yet after two edges", status[3], 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "uv after third edge", status[3], 1'b0);
    chk("R5", "uv fault pin", fault_od_en, 1'b1);
    supply_uv = 1'b0; settle();
    sw_write(1'b1);
    chk("R7", "software set standby next edge", standby, 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule